// File: doc/BRIEF.md
# Serial PSRAM bring-up sequencer

This block brings an external serial pseudo-static RAM into a known state after power-up. A one-cycle `start_i` pulse launches a fixed series of chip-select frames on a four-line serial memory bus. The series runs in this order. A quad-form exit command returns the device to single-line mode. An optional identifier read follows, from which the capacity is decoded. Next come a two-frame software reset (enable, then reset) and a final command that puts the device into quad mode. When the last frame has closed, `busy_o` drops and `done_o` rises.

The data lines use an output-enable style: the block drives `sio_o` on the lines whose `sio_oe_o` bit is set and reads `sio_i`. The serial clock runs at the system clock divided by `2*SCLK_HALF`. When size detection is disabled, the identifier frame is skipped and a configured size passes straight through to the size output. Array access after bring-up and pad multiplexing belong to other blocks.

Top module: `psram_boot_seq`

## Requirements
- R1: After reset, cs_n_o=1, sclk_o=0, sio_oe_o=0, busy_o=0, done_o=0, size_o=0 and present_o=0.
- R2: A start frames these commands, each in its own chip-select frame and in this order: quad exit 0xF5, identifier read 0x9F (only when auto_size_i=1 at start), 0x66, 0x99, 0x35.
- R3: The quad exit takes 2 serial clocks with sio_oe_o=4'hF. The high nibble goes out first, with nibble bit 3 on line 3.
- R4: The identifier frame has 56 serial clocks. It sends 0x9F and then a 24-bit zero address MSB first on line 0 with sio_oe_o=4'b0001. For the last 24 clocks sio_oe_o=0 and line 1 is sampled MSB first on each rising serial clock edge.
- R5: Commands 0x66, 0x99 and 0x35 each use exactly 8 serial clocks, MSB first on line 0.
- R6: For a detected identifier, the size code is id[23:21]. Code 2 gives size_o=8, code 1 gives size_o=4 and any other code gives size_o=2 (MiB), with present_o=1.
- R7: An identifier of 24'hFFFFFF gives size_o=0 and present_o=0.
- R8: With auto_size_i=0 at start, there is no identifier frame, size_o takes size_cfg_i, and present_o=1 exactly when size_cfg_i is nonzero.
- R9: Chip select stays high for at least 4*SCLK_HALF system clocks between frames, and sclk_o is low whenever chip select is high.
- R10: Each serial clock period is 2*SCLK_HALF system clocks. If a frame has N serial clocks, it costs 1+2*SCLK_HALF*N+4*SCLK_HALF cycles. busy_o is high from the edge that accepts start until the sum of these costs has elapsed, and on that edge done_o rises.
- R11: A start_i pulse while busy_o is high has no effect on the frames or the timing.
- R12: done_o holds high until the next accepted start clears it, and is never high together with busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, taken only when idle |
| auto_size_i | input | 1 | Read the identifier and decode the size |
| size_cfg_i | input | SIZE_W | Size in MiB used when detection is off |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, held until the next start |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| sio_o | output | 4 | Data line output values |
| sio_oe_o | output | 4 | Per-line output enable |
| sio_i | input | 4 | Data line input values |
| size_o | output | SIZE_W | Device size in MiB, 0 when absent |
| present_o | output | 1 | Device answered |

## Verification
After an accepted start, `busy_o` and `done_o` change exactly T edges later. T is the sum of the per-frame costs in R10: with SCLK_HALF=2 that is 373 cycles with detection and 140 without. The bench predicts T from the requirements, samples both outputs on every falling clock edge from the start edge onward, and compares them with the expected level for that cycle. A behavioural device model samples each rising serial clock. It drives identifier bits on falling serial clock edges, so each bit is stable for a full half period before it is captured. Serial clock periods and chip-select gaps are measured in system clocks against R9 and R10.

// File: rtl/psram_boot_pkg.sv
package psram_boot_pkg;
  localparam int CMD_W  = 8;
  localparam int ADDR_W = 24;
  localparam int ID_W   = 24;

  localparam logic [CMD_W-1:0] OP_QEXIT  = 8'hF5;
  localparam logic [CMD_W-1:0] OP_RDID   = 8'h9F;
  localparam logic [CMD_W-1:0] OP_RSTEN  = 8'h66;
  localparam logic [CMD_W-1:0] OP_RST    = 8'h99;
  localparam logic [CMD_W-1:0] OP_QENTER = 8'h35;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_EXIT, SQ_ID, SQ_RSTEN, SQ_RST, SQ_QEN
  } seq_e;

  typedef enum logic [1:0] {EN_IDLE, EN_SHIFT, EN_GAP} eng_e;

  typedef struct packed {
    logic [CMD_W-1:0] op;
    logic             quad;
    logic             with_addr;
    logic             with_rx;
  } frame_t;

  function automatic frame_t frame_of(seq_e s);
    frame_t f;
    f = '0;
    case (s)
      SQ_EXIT:  begin f.op = OP_QEXIT; f.quad = 1'b1; end
      SQ_ID:    begin f.op = OP_RDID; f.with_addr = 1'b1; f.with_rx = 1'b1; end
      SQ_RSTEN: f.op = OP_RSTEN;
      SQ_RST:   f.op = OP_RST;
      SQ_QEN:   f.op = OP_QENTER;
      default:  f = '0;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/psram_frame_engine.sv
module psram_frame_engine
  import psram_boot_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  frame_t          frame_i,
  output logic            idle_o,
  output logic            fin_o,
  output logic            cs_n_o,
  output logic            sclk_o,
  output logic [3:0]      sio_o,
  output logic [3:0]      sio_oe_o,
  input  logic [3:0]      sio_i,
  output logic [ID_W-1:0] rx_o
);
  localparam int SH_W    = CMD_W + ADDR_W;
  localparam int GAP_CYC = 4 * SCLK_HALF;
  localparam int CNT_W   = $clog2(GAP_CYC) + 1;
  localparam int BIT_W   = $clog2(CMD_W + ADDR_W + ID_W + 1);
  localparam logic [BIT_W-1:0] L_CMD  = BIT_W'(CMD_W);
  localparam logic [BIT_W-1:0] L_QCMD = BIT_W'(CMD_W / 4);
  localparam logic [BIT_W-1:0] L_ADDR = BIT_W'(ADDR_W);
  localparam logic [BIT_W-1:0] L_RX   = BIT_W'(ID_W);

  eng_e             st_q;
  logic             ph_q;
  logic             quad_q;
  logic [BIT_W-1:0] left_q;
  logic [BIT_W-1:0] rxn_q;
  logic [SH_W-1:0]  sh_q;
  logic [ID_W-1:0]  rx_q;
  logic [CNT_W-1:0] lim;
  logic             tick;
  logic             drive_out;

  assign lim = (st_q == EN_GAP) ? CNT_W'(GAP_CYC - 1) : CNT_W'(SCLK_HALF - 1);

  psram_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q == EN_IDLE),
    .lim_i  (lim),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= EN_IDLE;
      ph_q   <= 1'b0;
      quad_q <= 1'b0;
      left_q <= '0;
      rxn_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      case (st_q)
        EN_IDLE: if (go_i) begin
          st_q   <= EN_SHIFT;
          ph_q   <= 1'b0;
          quad_q <= frame_i.quad;
          sh_q   <= {frame_i.op, {ADDR_W{1'b0}}};
          left_q <= frame_i.quad ? L_QCMD
                    : L_CMD + (frame_i.with_addr ? L_ADDR : '0)
                            + (frame_i.with_rx ? L_RX : '0);
          rxn_q  <= frame_i.with_rx ? L_RX : '0;
        end
        EN_SHIFT: if (tick) begin
          ph_q <= ~ph_q;
          if (!ph_q) begin
            rx_q <= {rx_q[ID_W-2:0], sio_i[1]};
          end else begin
            if (left_q == BIT_W'(1)) st_q <= EN_GAP;
            else                     left_q <= left_q - 1'b1;
            sh_q <= quad_q ? {sh_q[SH_W-5:0], 4'b0000} : {sh_q[SH_W-2:0], 1'b0};
          end
        end
        EN_GAP: if (tick) st_q <= EN_IDLE;
        default: st_q <= EN_IDLE;
      endcase
    end
  end

  assign idle_o    = (st_q == EN_IDLE);
  assign fin_o     = (st_q == EN_GAP) && tick;
  assign cs_n_o    = (st_q != EN_SHIFT);
  assign sclk_o    = (st_q == EN_SHIFT) && ph_q;
  assign drive_out = (st_q == EN_SHIFT) && (quad_q || (left_q > rxn_q));
  assign rx_o      = rx_q;

  always_comb begin
    sio_oe_o = 4'b0000;
    sio_o    = 4'b0000;
    if (drive_out) begin
      if (quad_q) begin
        sio_oe_o = 4'b1111;
        sio_o    = sh_q[SH_W-1 -: 4];
      end else begin
        sio_oe_o = 4'b0001;
        sio_o    = {3'b000, sh_q[SH_W-1]};
      end
    end
  end
endmodule

// File: rtl/psram_id_decode.sv
module psram_id_decode
  import psram_boot_pkg::*;
#(
  parameter int SIZE_W = 4
) (
  input  logic [ID_W-1:0]   id_i,
  output logic              present_o,
  output logic [SIZE_W-1:0] size_o
);
  logic [2:0] code;

  assign code      = id_i[ID_W-1 -: 3];
  assign present_o = ~&id_i;

  always_comb begin
    if (!present_o) size_o = '0;
    else begin
      case (code)
        3'd2:    size_o = SIZE_W'(8);
        3'd1:    size_o = SIZE_W'(4);
        default: size_o = SIZE_W'(2);
      endcase
    end
  end
endmodule

// File: rtl/psram_boot_seq.sv
module psram_boot_seq
  import psram_boot_pkg::*;
#(
  parameter int SCLK_HALF = 2,
  parameter int SIZE_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              auto_size_i,
  input  logic [SIZE_W-1:0] size_cfg_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic [3:0]        sio_o,
  output logic [3:0]        sio_oe_o,
  input  logic [3:0]        sio_i,
  output logic [SIZE_W-1:0] size_o,
  output logic              present_o
);
  seq_e              seq_q;
  logic              auto_q;
  logic              done_q;
  logic [SIZE_W-1:0] size_q;
  logic              present_q;
  logic              eng_idle;
  logic              eng_fin;
  logic              go;
  logic [ID_W-1:0]   id_raw;
  logic              dec_present;
  logic [SIZE_W-1:0] dec_size;

  assign go = (seq_q != SQ_IDLE) && eng_idle;

  psram_frame_engine #(.SCLK_HALF(SCLK_HALF)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .frame_i  (frame_of(seq_q)),
    .idle_o   (eng_idle),
    .fin_o    (eng_fin),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .sio_o    (sio_o),
    .sio_oe_o (sio_oe_o),
    .sio_i    (sio_i),
    .rx_o     (id_raw)
  );

  psram_id_decode #(.SIZE_W(SIZE_W)) u_dec (
    .id_i      (id_raw),
    .present_o (dec_present),
    .size_o    (dec_size)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q     <= SQ_IDLE;
      auto_q    <= 1'b0;
      done_q    <= 1'b0;
      size_q    <= '0;
      present_q <= 1'b0;
    end else if (seq_q == SQ_IDLE) begin
      if (start_i) begin
        seq_q  <= SQ_EXIT;
        auto_q <= auto_size_i;
        done_q <= 1'b0;
        if (auto_size_i) begin
          size_q    <= '0;
          present_q <= 1'b0;
        end else begin
          size_q    <= size_cfg_i;
          present_q <= |size_cfg_i;
        end
      end
    end else if (eng_fin) begin
      case (seq_q)
        SQ_EXIT:  seq_q <= auto_q ? SQ_ID : SQ_RSTEN;
        SQ_ID: begin
          size_q    <= dec_size;
          present_q <= dec_present;
          seq_q     <= SQ_RSTEN;
        end
        SQ_RSTEN: seq_q <= SQ_RST;
        SQ_RST:   seq_q <= SQ_QEN;
        default: begin
          seq_q  <= SQ_IDLE;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  assign busy_o    = (seq_q != SQ_IDLE);
  assign done_o    = done_q;
  assign size_o    = size_q;
  assign present_o = present_q;
endmodule

// File: rtl/psram_boot_seq_chk.sv
module psram_boot_seq_chk #(
  parameter int SIZE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              sclk_o,
  input logic              cs_n_o,
  input logic [3:0]        sio_oe_o,
  input logic [SIZE_W-1:0] size_o,
  input logic              present_o
);
  a_r9_sclk_low_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o);
  a_r10_rise_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> !cs_n_o);
  a_r12_done_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));
  a_r12_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  a_r2_frames_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_n_o);
  a_r3_oe_shapes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sio_oe_o == 4'b0000) || (sio_oe_o == 4'b0001) || (sio_oe_o == 4'b1111));
  a_r4_lines_free_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> (sio_oe_o == 4'b0000));
  a_r7_absent_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!present_o && !busy_o) |-> (size_o == '0));
endmodule

bind psram_boot_seq psram_boot_seq_chk #(.SIZE_W(SIZE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .sclk_o    (sclk_o),
  .cs_n_o    (cs_n_o),
  .sio_oe_o  (sio_oe_o),
  .size_o    (size_o),
  .present_o (present_o)
);

// File: tb/psram_boot_seq_tb_top.sv
module psram_boot_seq_tb_top;
  localparam int H  = 2;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          auto_sz = 1'b0;
  logic [SW-1:0] size_cfg = '0;
  logic          busy, done, sclk, cs_n, present;
  logic [3:0]    sio_out, sio_oe, sio_in;
  logic [SW-1:0] size;
  logic          miso = 1'b0;

  always #4 clk = ~clk;
  assign sio_in = {2'b00, miso, 1'b0};

  psram_boot_seq #(.SCLK_HALF(H), .SIZE_W(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .auto_size_i(auto_sz),
    .size_cfg_i(size_cfg), .busy_o(busy), .done_o(done), .sclk_o(sclk),
    .cs_n_o(cs_n), .sio_o(sio_out), .sio_oe_o(sio_oe), .sio_i(sio_in),
    .size_o(size), .present_o(present)
  );

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural device model
  logic [23:0] dev_id = '0;
  int          clk_n = 0;
  logic [3:0]  smp_d  [64];
  logic [3:0]  smp_oe [64];
  bit          per_bad = 0;
  int          since = -1;
  logic        prev_sclk = 1'b0, prev_cs = 1'b1;
  int          hi_run = 0;
  bit          seen_frame = 0, gap_bad = 0;
  int q_op[$], q_clk[$], q_quad[$], q_addr[$], q_rxrel[$], q_per[$];

  always @(negedge cs_n) begin
    clk_n = 0;
    per_bad = 0;
  end

  always @(posedge sclk) if (!cs_n) begin
    if (clk_n < 64) begin
      smp_d[clk_n]  = sio_out;
      smp_oe[clk_n] = sio_oe;
    end
    clk_n++;
  end

  always @(negedge sclk) if (!cs_n && clk_n >= 32 && clk_n < 56) miso = dev_id[55-clk_n];

  always @(posedge cs_n) if (rst_n) begin
    int op, ad, rel;
    bit q;
    q = (smp_oe[0] == 4'hF);
    op = 0; ad = 0; rel = 1;
    if (q) op = {smp_d[0], smp_d[1]};
    else for (int i = 0; i < 8; i++) op = (op << 1) | int'(smp_d[i][0]);
    if (clk_n == 56) begin
      for (int i = 8; i < 32; i++) ad = (ad << 1) | int'(smp_d[i][0]);
      for (int i = 32; i < 56; i++) if (smp_oe[i] != 4'h0) rel = 0;
    end
    q_op.push_back(op); q_clk.push_back(clk_n); q_quad.push_back(int'(q));
    q_addr.push_back(ad); q_rxrel.push_back(rel); q_per.push_back(int'(per_bad));
  end

  always @(negedge clk) begin
    if (since >= 0) since++;
    if (cs_n) since = -1;
    else if (sclk && !prev_sclk) begin
      if (since > 0 && since != 2*H) per_bad = 1;
      since = 0;
    end
    prev_sclk = sclk;
    if (cs_n) hi_run++;
    else begin
      if (prev_cs && seen_frame && hi_run < 4*H) gap_bad = 1;
      if (prev_cs) seen_frame = 1;
      hi_run = 0;
    end
    prev_cs = cs_n;
  end

  function automatic int cost(int n);
    return 1 + 2*H*n + 4*H;
  endfunction

  task automatic run_seq(input bit au, input logic [SW-1:0] cfg, input logic [23:0] id,
                         input int exp_size, input int exp_pres, input bit poke);
    int t, nf, busy_err, done_err;
    int e_op[5], e_n[5], e_q[5];
    dev_id = id;
    q_op.delete(); q_clk.delete(); q_quad.delete();
    q_addr.delete(); q_rxrel.delete(); q_per.delete();
    seen_frame = 0; gap_bad = 0;
    nf = 0;
    e_op[nf] = 'hF5; e_n[nf] = 2; e_q[nf] = 1; nf++;
    if (au) begin e_op[nf] = 'h9F; e_n[nf] = 56; e_q[nf] = 0; nf++; end
    e_op[nf] = 'h66; e_n[nf] = 8; e_q[nf] = 0; nf++;
    e_op[nf] = 'h99; e_n[nf] = 8; e_q[nf] = 0; nf++;
    e_op[nf] = 'h35; e_n[nf] = 8; e_q[nf] = 0; nf++;
    t = 0;
    for (int i = 0; i < nf; i++) t += cost(e_n[i]);
    @(negedge clk);
    auto_sz = au; size_cfg = cfg; start = 1'b1;
    busy_err = 0; done_err = 0;
    for (int j = 0; j < t + 4; j++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && j == 40) start = 1'b1;  // R11 stray start while busy
      if (busy !== (j < t)) busy_err++;
      if (done !== (j >= t)) done_err++;
    end
    chk(busy_err == 0, "R10 busy window", busy_err, 0);
    chk(done_err == 0, "R12 done timing/hold", done_err, 0);
    if (poke) chk(q_op.size() == nf, "R11 no extra frames", q_op.size(), nf);
    chk(q_op.size() == nf, "R2 frame count", q_op.size(), nf);
    if (q_op.size() == nf) begin
      for (int i = 0; i < nf; i++) begin
        chk(q_op[i] == e_op[i], "R2 command order", q_op[i], e_op[i]);
        chk(q_quad[i] == e_q[i], "R3 quad form", q_quad[i], e_q[i]);
        chk(q_clk[i] == e_n[i], (e_n[i] == 8) ? "R5 clocks" : "R4 clocks", q_clk[i], e_n[i]);
        chk(q_per[i] == 0, "R10 sclk period", q_per[i], 0);
        if (e_n[i] == 56) begin
          chk(q_addr[i] == 0, "R4 zero address", q_addr[i], 0);
          chk(q_rxrel[i] == 1, "R4 line0 released", q_rxrel[i], 1);
        end
      end
    end
    chk(gap_bad == 0, "R9 cs gap", int'(gap_bad), 0);
    chk(int'(size) == exp_size, au ? ((exp_pres != 0) ? "R6 size" : "R7 size") : "R8 size",
        int'(size), exp_size);
    chk(int'(present) == exp_pres, au ? "R7 present" : "R8 present", int'(present), exp_pres);
  endtask

  task automatic finish_tb;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8*100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_tb();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1 bus idle in reset", {cs_n, sclk}, 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 status", {busy, done}, 0);
    chk(sio_oe === 4'h0 && cs_n === 1'b1 && sclk === 1'b0, "R1 lines", int'(sio_oe), 0);
    chk(size === '0 && present === 1'b0, "R1 size", int'(size), 0);
    run_seq(1'b1, 4'd0, 24'h5D0D12, 8, 1, 1'b1);
    run_seq(1'b1, 4'd0, 24'h2E0D12, 4, 1, 1'b0);
    run_seq(1'b1, 4'd0, 24'hC50D12, 2, 1, 1'b0);
    run_seq(1'b1, 4'd0, 24'h1A0D12, 2, 1, 1'b0);
    run_seq(1'b1, 4'd0, 24'hFFFFFF, 0, 0, 1'b0);
    run_seq(1'b0, 4'd8, 24'h5D0D12, 8, 1, 1'b0);
    run_seq(1'b0, 4'd0, 24'h5D0D12, 0, 0, 1'b0);
    finish_tb();
  end
endmodule